// File: doc/BRIEF.md
# Word-window transfer buffer

This block holds the data staged for, or returned by, a serial flash transaction. The buffer is a byte array. Software does not see it as a memory range. It reaches the array through a small register window instead: a control register that sets the transfer direction, an auto-advance enable and a word pointer, and a data register that moves one 32-bit word per access. With auto-advance on, software can stream a whole transfer by hitting the same data address again and again. A third register holds the byte offset from which the flash sequencer works.

The sequencer has its own byte-wide port. Each sequencer access addresses the byte at the start offset plus a running index, taken modulo the buffer size. A transfer whose length is not a multiple of four is moved by software in whole words. The last word then carries the tail bytes in its low lanes.

Both ports are plain synchronous interfaces. Writes take effect at the clock edge. Read data appears on the port one cycle after the read strobe and holds until the next read on that port.

Top module: `wordwin_buf`

## Requirements
- R1: After reset, the direction bit, the auto-advance bit, the word pointer and the start offset are all 0, so a read of the control register returns 0 and a read of the start-offset register returns 0.
- R2: `sw_addr` selects the register: 0 is the control register, 1 is the data register, 2 is the start offset, and 3 reads 0. Control bit 31 is the direction (1 = software fills the buffer, 0 = software drains it), and bit 30 is the auto-advance enable. The low bits of the 8-bit field [7:0] hold the word pointer, which is log2(BYTES/4) bits wide, so 7 bits by default. A control write loads all three fields. Pointer bits above the pointer width are dropped on write and read back as 0.
- R3: With direction 1, a data-register write stores the word at the pointer in little-endian order: bits [8k+7:8k] go to byte address 4*pointer+k.
- R4: With direction 0, a data-register read returns the word at the pointer on `sw_rdata` in the cycle after the read strobe, assembled little-endian.
- R5: Each effective data access advances the pointer by one when auto-advance is 1. The pointer holds when auto-advance is 0.
- R6: Advancing from the last word (BYTES/4-1) wraps the pointer to word 0.
- R7: A data write while the direction is 0 stores nothing and does not move the pointer. A data read while the direction is 1 returns 0 and does not move the pointer.
- R8: The start-offset register is log2(BYTES) bits wide (9 by default), is written at address 2 and reads back zero-extended.
- R9: A sequencer access with `sq_en` high addresses byte (start offset + `sq_idx`) modulo BYTES. With `sq_we` high it stores `sq_wdata`. Otherwise the byte appears on `sq_rdata` one cycle later.
- R10: A sequencer transfer of N bytes, where N is not a multiple of 4, is read back by software in ceil(N/4) words. The final word holds the N mod 4 tail bytes in its low lanes.
- R11: When both ports write the same byte in the same cycle, the software port's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr | input | 2 | Software register select |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe (ignored when `sw_wr` is high) |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, valid the cycle after `sw_rd` |
| sq_en | input | 1 | Sequencer access strobe |
| sq_we | input | 1 | Sequencer write (1) or read (0) |
| sq_idx | input | 9 | Byte index relative to the start offset |
| sq_wdata | input | 8 | Sequencer write byte |
| sq_rdata | output | 8 | Sequencer read byte, valid the cycle after a read |

## Verification
The bench builds the block with its default 512-byte buffer. The pointer is therefore 7 bits wide and the last word is 127. At this size the pointer wrap is one write away once the pointer is loaded with 127. Bit 7 of the pointer field can also be written and shown to read back 0. A start offset of 510 makes a five-byte sequencer burst cross the top of the array, so the modulo byte addressing and the word it straddles are checked against a byte-level model kept in the bench.

// File: rtl/wordwin_buf.sv
module wordwin_buf #(
  parameter int BYTES = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               sw_addr,
  input  logic                     sw_wr,
  input  logic                     sw_rd,
  input  logic [31:0]              sw_wdata,
  output logic [31:0]              sw_rdata,
  input  logic                     sq_en,
  input  logic                     sq_we,
  input  logic [$clog2(BYTES)-1:0] sq_idx,
  input  logic [7:0]               sq_wdata,
  output logic [7:0]               sq_rdata
);
  localparam int WORDS = BYTES / 4;
  localparam int PW    = $clog2(WORDS);
  localparam int OW    = $clog2(BYTES);

  logic [7:0]    mem [BYTES];
  logic          dir, auto;
  logic [PW-1:0] ptr;
  logic [OW-1:0] start;

  wire ctrl_wr  = sw_wr && sw_addr == 2'd0;
  wire start_wr = sw_wr && sw_addr == 2'd2;
  wire data_wr  = sw_wr && sw_addr == 2'd1 && dir;
  wire rd_go    = sw_rd && !sw_wr;
  wire data_rd  = rd_go && sw_addr == 2'd1 && !dir;
  wire step     = (data_wr || data_rd) && auto;

  wire [OW-1:0] wbase   = {ptr, 2'b00};
  wire [OW-1:0] sq_addr = start + sq_idx;
  wire [31:0]   cur_word = {mem[wbase + OW'(3)], mem[wbase + OW'(2)],
                            mem[wbase + OW'(1)], mem[wbase]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir   <= 1'b0;
      auto  <= 1'b0;
      ptr   <= '0;
      start <= '0;
    end else begin
      if (ctrl_wr) begin
        dir  <= sw_wdata[31];
        auto <= sw_wdata[30];
        ptr  <= sw_wdata[PW-1:0];
      end else if (step) begin
        ptr <= ptr + 1'b1;
      end
      if (start_wr) start <= sw_wdata[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (sq_en && sq_we) mem[sq_addr] <= sq_wdata;
    if (data_wr)
      for (int k = 0; k < 4; k++) mem[wbase + OW'(k)] <= sw_wdata[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_rdata <= '0;
      sq_rdata <= '0;
    end else begin
      if (rd_go) begin
        case (sw_addr)
          2'd0:    sw_rdata <= {dir, auto, {(30-PW){1'b0}}, ptr};
          2'd1:    sw_rdata <= dir ? 32'd0 : cur_word;
          2'd2:    sw_rdata <= {{(32-OW){1'b0}}, start};
          default: sw_rdata <= 32'd0;
        endcase
      end
      if (sq_en && !sq_we) sq_rdata <= mem[sq_addr];
    end
  end
endmodule

// File: rtl/wordwin_buf_chk.sv
module wordwin_buf_chk #(
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sw_addr,
  input logic          sw_wr,
  input logic          sw_rd,
  input logic [31:0]   sw_wdata,
  input logic [31:0]   sw_rdata,
  input logic          dir,
  input logic          auto,
  input logic [PW-1:0] ptr
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (ptr == '0 && !dir && !auto));

  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == 2'd0) |=> ptr == $past(sw_wdata[PW-1:0]));

  a_r2_ctrl_view: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && !sw_wr && sw_addr == 2'd0) |=>
      (sw_rdata[31] == $past(dir) && sw_rdata[30] == $past(auto)));

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == 2'd1 && dir && auto) |=> ptr == PW'($past(ptr) + 1'b1));

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == 2'd1 && !auto) |=> $stable(ptr));

  a_r7_wrong_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == 2'd1 && !dir) |=> $stable(ptr));

  a_r7_wrong_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && !sw_wr && sw_addr == 2'd1 && dir) |=> (sw_rdata == 32'd0 && $stable(ptr)));
endmodule

bind wordwin_buf wordwin_buf_chk #(.PW($clog2(BYTES/4))) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_rd(sw_rd),
  .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .dir(dir), .auto(auto), .ptr(ptr)
);

// File: tb/sim_wordwin_buf.sv
module sim_wordwin_buf;
  localparam int BYTES = 512;
  localparam int OW = $clog2(BYTES);

  logic clk = 0, rst_n = 0;
  logic [1:0] sw_addr = 0;
  logic sw_wr = 0, sw_rd = 0;
  logic [31:0] sw_wdata = 0, sw_rdata;
  logic sq_en = 0, sq_we = 0;
  logic [OW-1:0] sq_idx = 0;
  logic [7:0] sq_wdata = 0, sq_rdata;

  int ntot = 0, nfail = 0;
  bit done = 0;
  logic [7:0] mdl [BYTES];
  logic [OW-1:0] mstart = 0;

  always #4 clk = ~clk;

  wordwin_buf #(.BYTES(BYTES)) u0 (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    ntot++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit d, input bit a, input int p);
    return {d, a, 22'd0, 8'(p)};
  endfunction

  function automatic logic [31:0] mword(input int w);
    return {mdl[4*w+3], mdl[4*w+2], mdl[4*w+1], mdl[4*w]};
  endfunction

  task automatic sw_put(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); sw_addr = a; sw_wdata = d; sw_wr = 1;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic sw_get(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); sw_addr = a; sw_rd = 1;
    @(negedge clk); sw_rd = 0; d = sw_rdata;
  endtask

  task automatic sq_put(input int idx, input logic [7:0] b);
    @(negedge clk); sq_en = 1; sq_we = 1; sq_idx = OW'(idx); sq_wdata = b;
    @(negedge clk); sq_en = 0; sq_we = 0;
    mdl[OW'(mstart + OW'(idx))] = b;
  endtask

  task automatic sq_get(input int idx, output logic [7:0] b);
    @(negedge clk); sq_en = 1; sq_we = 0; sq_idx = OW'(idx);
    @(negedge clk); sq_en = 0; b = sq_rdata;
  endtask

  task automatic fill_word(input int p, input logic [31:0] d);
    for (int k = 0; k < 4; k++) mdl[4*p+k] = d[8*k +: 8];
  endtask

  task automatic t_reset;
    logic [31:0] r;
    sw_get(2'd0, r); check("R1 control after reset", r, 32'd0);
    sw_get(2'd2, r); check("R1 start offset after reset", r, 32'd0);
  endtask

  task automatic t_ctrl;
    logic [31:0] r;
    sw_put(2'd0, 32'hC000_00FF);
    sw_get(2'd0, r); check("R2 control readback, pointer bit 7 dropped", r, 32'hC000_007F);
    sw_get(2'd3, r); check("R2 reserved address reads 0", r, 32'd0);
  endtask

  task automatic t_stream;
    logic [31:0] r;
    sw_put(2'd0, ctl(1, 1, 0));
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d = 32'h1020_3040 * (i + 1) ^ 32'h0F0F_0F0F;
      sw_put(2'd1, d); fill_word(i, d);
    end
    sw_get(2'd0, r); check("R5 pointer after 8 writes", r, ctl(1, 1, 8));
    sw_put(2'd0, ctl(0, 1, 0));
    for (int i = 0; i < 8; i++) begin
      sw_get(2'd1, r); check("R3/R4 streamed word readback", r, mword(i));
    end
    for (int k = 0; k < 4; k++) check("R3 little-endian lane", {24'd0, r[8*k +: 8]}, {24'd0, mdl[28+k]});
    sw_get(2'd0, r); check("R5 pointer after 8 reads", r, ctl(0, 1, 8));
  endtask

  task automatic t_no_auto;
    logic [31:0] r;
    sw_put(2'd0, ctl(1, 0, 10));
    sw_put(2'd1, 32'hAAAA_0001);
    sw_put(2'd1, 32'hBBBB_0002); fill_word(10, 32'hBBBB_0002);
    sw_get(2'd0, r); check("R5 pointer holds without auto-advance", r, ctl(1, 0, 10));
    sw_put(2'd0, ctl(0, 0, 10));
    sw_get(2'd1, r); check("R5 second write overwrote same word", r, 32'hBBBB_0002);
    sw_get(2'd1, r); check("R5 repeated read same word", r, 32'hBBBB_0002);
    sw_get(2'd0, r); check("R5 pointer holds after reads", r, ctl(0, 0, 10));
  endtask

  task automatic t_wrap;
    logic [31:0] r;
    sw_put(2'd0, ctl(1, 1, 127));
    sw_put(2'd1, 32'h7777_7F7F); fill_word(127, 32'h7777_7F7F);
    sw_get(2'd0, r); check("R6 pointer wrapped to 0", r, ctl(1, 1, 0));
    sw_put(2'd1, 32'h0000_F00D); fill_word(0, 32'h0000_F00D);
    sw_get(2'd0, r); check("R6 pointer after wrap write", r, ctl(1, 1, 1));
    sw_put(2'd0, ctl(0, 1, 127));
    sw_get(2'd1, r); check("R6 last word", r, 32'h7777_7F7F);
    sw_get(2'd1, r); check("R6 first word after wrap", r, 32'h0000_F00D);
  endtask

  task automatic t_mismatch;
    logic [31:0] r;
    sw_put(2'd0, ctl(1, 1, 20));
    sw_put(2'd1, 32'h2020_2020); fill_word(20, 32'h2020_2020);
    sw_put(2'd0, ctl(0, 1, 20));
    sw_put(2'd1, 32'hDEAD_BEEF);
    sw_get(2'd0, r); check("R7 write in read direction keeps pointer", r, ctl(0, 1, 20));
    sw_get(2'd1, r); check("R7 write in read direction stored nothing", r, 32'h2020_2020);
    sw_put(2'd0, ctl(1, 1, 20));
    sw_get(2'd1, r); check("R7 read in write direction returns 0", r, 32'd0);
    sw_get(2'd0, r); check("R7 read in write direction keeps pointer", r, ctl(1, 1, 20));
  endtask

  task automatic t_seq;
    logic [31:0] r;
    logic [7:0] b;
    sw_put(2'd2, 32'h0000_01FE); mstart = 9'h1FE;
    sw_get(2'd2, r); check("R8 start offset readback", r, 32'h0000_01FE);
    for (int i = 0; i < 5; i++) sq_put(i, 8'h51 + 8'(i));
    sw_put(2'd0, ctl(0, 1, 127));
    sw_get(2'd1, r); check("R9 sequencer bytes at top of buffer", r, mword(127));
    sw_get(2'd1, r); check("R9 sequencer bytes wrapped to byte 0", r, mword(0));
    check("R9 wrapped byte value", {24'd0, r[23:16]}, 32'h55);
    sq_get(1, b); check("R9 sequencer read at start+1", {24'd0, b}, {24'd0, mdl[511]});
    sq_get(3, b); check("R9 sequencer read wraps", {24'd0, b}, 32'h54);
  endtask

  task automatic t_partial;
    logic [31:0] r;
    sw_put(2'd2, 32'd8); mstart = 9'd8;
    for (int i = 0; i < 7; i++) sq_put(i, 8'hC0 + 8'(i));
    sw_put(2'd0, ctl(0, 1, 2));
    sw_get(2'd1, r); check("R10 first full word", r, 32'hC3C2_C1C0);
    sw_get(2'd1, r); check("R10 tail bytes in low lanes", {8'd0, r[23:0]}, 32'h00C6_C5C4);
  endtask

  task automatic t_collide;
    logic [31:0] r;
    sw_put(2'd2, 32'd0); mstart = 0;
    sw_put(2'd0, ctl(1, 1, 40));
    @(negedge clk);
    sw_addr = 2'd1; sw_wdata = 32'hA1B2_C3D4; sw_wr = 1;
    sq_en = 1; sq_we = 1; sq_idx = 9'd161; sq_wdata = 8'h99;
    @(negedge clk);
    sw_wr = 0; sq_en = 0; sq_we = 0;
    sw_put(2'd0, ctl(0, 0, 40));
    sw_get(2'd1, r); check("R11 software wins same-byte collision", r, 32'hA1B2_C3D4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_stream();
    t_no_auto();
    t_wrap();
    t_mismatch();
    t_seq();
    t_partial();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end
endmodule